// File: doc/BRIEF.md
# Bus Cycle Wait-State Generator

This block stretches each bus cycle of a 5 MHz processor by 0 to 7 clock periods. It watches the address latch enable strobe. On its falling edge it takes the region code from the memory decoder and the memory/IO qualifier, and from them picks a wait count. It then holds its ready request low, towards the clock generator, for that many clock periods. The clock generator's own ready synchroniser is not part of this block.

The counts are fixed. Read-only code memory gets two waits. Static RAM gets one wait, for reads and writes alike. Any I/O cycle gets none. A memory cycle to a region the decoder does not map takes its count from a default register. That register resets to 7 and is rewritten from a 3-bit input whenever a load strobe is pulsed. If a new cycle starts while waits are still being counted, the count starts again with the new cycle's value.

Top module: `bus_wait_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `rdyReq` high and `busy` low, and sets the default count to 7.
- R2: A count is loaded only at a clock edge where `ale` is sampled low after it was sampled high at the previous edge. `regionCode` and `memNotIo` are sampled at that same edge.
- R3: A memory cycle (`memNotIo`=1) with `regionCode`=2'b10 (read-only code memory) holds `rdyReq` low for exactly 2 clock periods after the load edge.
- R4: A memory cycle with `regionCode`=2'b01 (static RAM) holds `rdyReq` low for exactly 1 clock period.
- R5: An I/O cycle (`memNotIo`=0) never takes `rdyReq` low, whatever `regionCode` is.
- R6: A memory cycle with `regionCode`=2'b00 or 2'b11 (unmapped) holds `rdyReq` low for the number of periods held in the default register.
- R7: When `cfgLoad` is high at a clock edge, `cfgWaits` (0 to 7) is stored as the default count. It applies to later unmapped cycles, and a value of 0 gives no wait at all.
- R8: `busy` is high exactly while `rdyReq` is low. With a nonzero count, the counter steps down by one each clock until it reaches zero.
- R9: A falling `ale` while waits remain reloads the counter from the new cycle's region, discarding the old count.
- R10: While `ale` stays high, or stays low after its edge, no count is reloaded and `rdyReq` stays high once the waits have run out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address latch enable, a cycle starts on its fall |
| regionCode | input | 2 | Decoder region: 00/11 unmapped, 01 RAM, 10 code memory |
| memNotIo | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| cfgLoad | input | 1 | Store `cfgWaits` as the default count |
| cfgWaits | input | 3 | New default count for unmapped regions |
| rdyReq | output | 1 | Ready request to the clock generator, low while waiting |
| busy | output | 1 | High while wait states remain |

## Verification
The bench measures how many periods `rdyReq` stays low for each region, in both memory and I/O cycles. A wrong lookup shows up as a wrong length, and an off-by-one counter stretches or shortens every nonzero cycle. It restarts a code-memory cycle midway into an unmapped cycle with a changed default. A design that ignores the restart, or that adds the new count to the old one, releases ready at the wrong time. It also holds `ale` high and low for long stretches. A design that triggers on the level rather than on the fall would keep reloading and never release ready. A zero default and the reset value of 7 cover both ends of the count range.

// File: rtl/ws_pkg.sv
package ws_pkg;
  typedef enum logic [1:0] {
    REG_NONE  = 2'b00,
    REG_SRAM  = 2'b01,
    REG_EPROM = 2'b10,
    REG_SPARE = 2'b11
  } regionT;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'b00,
    SRC_SRAM  = 2'b01,
    SRC_EPROM = 2'b10,
    SRC_DEF   = 2'b11
  } srcT;

  typedef struct packed {
    logic load;
    logic step;
    logic cfgWr;
    srcT  src;
  } strobeT;
endpackage

// File: rtl/ws_ctrl.sv
module ws_ctrl
  import ws_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ale,
  input  logic [1:0] regionCode,
  input  logic       memNotIo,
  input  logic       cfgLoad,
  input  logic       cntZero,
  output strobeT     strb
);
  logic aleQ;
  logic aleFall;

  always_ff @(posedge clk) begin
    if (rst) aleQ <= 1'b0;
    else     aleQ <= ale;
  end

  assign aleFall = aleQ & ~ale;

  always_comb begin
    strb       = '0;
    strb.load  = aleFall;
    strb.step  = ~aleFall & ~cntZero;
    strb.cfgWr = cfgLoad;
    if (!memNotIo) begin
      strb.src = SRC_ZERO;
    end else begin
      unique case (regionT'(regionCode))
        REG_SRAM:  strb.src = SRC_SRAM;
        REG_EPROM: strb.src = SRC_EPROM;
        default:   strb.src = SRC_DEF;
      endcase
    end
  end

  // R2: a load only follows an edge where ale was seen high
  assert_load_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    strb.load |-> ($past(ale) && !ale));

  // R10: ale stable across two edges never produces a load
  assert_no_level_load_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(ale) == ale) |-> !strb.load);
endmodule

// File: rtl/ws_datapath.sv
module ws_datapath
  import ws_pkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int SRAM_WAITS  = 1,
  parameter int EPROM_WAITS = 2,
  parameter int DEF_RESET   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  strobeT           strb,
  input  logic [CNT_W-1:0] cfgWaits,
  output logic             cntZero,
  output logic             rdyReq,
  output logic             busy
);
  localparam logic [CNT_W-1:0] SramCnt  = CNT_W'(SRAM_WAITS);
  localparam logic [CNT_W-1:0] EpromCnt = CNT_W'(EPROM_WAITS);
  localparam logic [CNT_W-1:0] DefInit  = CNT_W'(DEF_RESET);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] defReg;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    unique case (strb.src)
      SRC_SRAM:  loadVal = SramCnt;
      SRC_EPROM: loadVal = EpromCnt;
      SRC_DEF:   loadVal = defReg;
      default:   loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)             defReg <= DefInit;
    else if (strb.cfgWr) defReg <= cfgWaits;
  end

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (strb.load) cnt <= loadVal;
    else if (strb.step) cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);
  assign rdyReq  = cntZero;
  assign busy    = ~cntZero;

  // R1: reset releases ready and clears busy
  assert_reset_ready_R1: assert property (@(posedge clk)
    rst |=> (rdyReq && !busy));

  // R3: a nonzero load pulls ready low on the next cycle
  assert_load_waits_R3: assert property (@(posedge clk) disable iff (rst)
    (strb.load && loadVal != '0) |=> !rdyReq);

  // R8: the counter steps down by exactly one
  assert_step_down_R8: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && !cntZero) |=> (cnt == $past(cnt) - 1'b1));

  // R7: the default register takes the written value
  assert_cfg_write_R7: assert property (@(posedge clk) disable iff (rst)
    strb.cfgWr |=> (defReg == $past(cfgWaits)));
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
  import ws_pkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int SRAM_WAITS  = 1,
  parameter int EPROM_WAITS = 2,
  parameter int DEF_RESET   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ale,
  input  logic [1:0]       regionCode,
  input  logic             memNotIo,
  input  logic             cfgLoad,
  input  logic [CNT_W-1:0] cfgWaits,
  output logic             rdyReq,
  output logic             busy
);
  strobeT strb;
  logic   cntZero;

  ws_ctrl uCtrl (
    .clk        (clk),
    .rst        (rst),
    .ale        (ale),
    .regionCode (regionCode),
    .memNotIo   (memNotIo),
    .cfgLoad    (cfgLoad),
    .cntZero    (cntZero),
    .strb       (strb)
  );

  ws_datapath #(
    .CNT_W       (CNT_W),
    .SRAM_WAITS  (SRAM_WAITS),
    .EPROM_WAITS (EPROM_WAITS),
    .DEF_RESET   (DEF_RESET)
  ) uData (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .cfgWaits (cfgWaits),
    .cntZero  (cntZero),
    .rdyReq   (rdyReq),
    .busy     (busy)
  );

  // R5: an I/O cycle start never leaves ready low afterwards
  assert_io_no_wait_R5: assert property (@(posedge clk) disable iff (rst)
    (strb.load && !memNotIo) |=> rdyReq);
endmodule

// File: tb/sim_bus_wait_gen.sv
module sim_bus_wait_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ale = 1'b0;
  logic [1:0] regionCode = 2'b00;
  logic       memNotIo = 1'b0;
  logic       cfgLoad = 1'b0;
  logic [2:0] cfgWaits = 3'd0;
  logic       rdyReq;
  logic       busy;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  bus_wait_gen u0 (
    .clk(clk), .rst(rst), .ale(ale), .regionCode(regionCode),
    .memNotIo(memNotIo), .cfgLoad(cfgLoad), .cfgWaits(cfgWaits),
    .rdyReq(rdyReq), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // start a cycle: ale high for one period, then low with the cycle attributes
  task automatic startCycle(input logic [1:0] rc, input logic mio);
    @(negedge clk);
    ale = 1'b1;
    @(negedge clk);
    ale = 1'b0;
    regionCode = rc;
    memNotIo = mio;
    @(posedge clk);
    #2;
  endtask

  // count sampled periods with ready low, checking busy alongside
  task automatic countLow(input string req, output int n);
    n = 0;
    while (!rdyReq && n < 12) begin
      check({req, " busy"}, busy, 1);
      n++;
      @(posedge clk);
      #2;
    end
    check({req, " busy idle"}, busy, 0);
  endtask

  task automatic runCycle(input string req, input logic [1:0] rc,
                          input logic mio, input int exp);
    int n;
    startCycle(rc, mio);
    countLow(req, n);
    check(req, n, exp);
  endtask

  task automatic writeDefault(input logic [2:0] v);
    @(negedge clk);
    cfgLoad = 1'b1;
    cfgWaits = v;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic testReset();
    check("R1 rdyReq", rdyReq, 1);
    check("R1 busy", busy, 0);
    runCycle("R1 default 7", 2'b00, 1'b1, 7);
  endtask

  task automatic testRegions();
    runCycle("R3 code mem", 2'b10, 1'b1, 2);
    runCycle("R4 ram", 2'b01, 1'b1, 1);
    runCycle("R5 io r0", 2'b00, 1'b0, 0);
    runCycle("R5 io r1", 2'b01, 1'b0, 0);
    runCycle("R5 io r2", 2'b10, 1'b0, 0);
    runCycle("R6 unmapped 11", 2'b11, 1'b1, 7);
  endtask

  task automatic testConfig();
    writeDefault(3'd4);
    runCycle("R7 default 4", 2'b00, 1'b1, 4);
    runCycle("R6 spare 4", 2'b11, 1'b1, 4);
    writeDefault(3'd0);
    runCycle("R7 default 0", 2'b11, 1'b1, 0);
    writeDefault(3'd5);
  endtask

  task automatic testRestart();
    int n;
    startCycle(2'b10, 1'b1);
    check("R8 first low", rdyReq, 0);
    startCycle(2'b00, 1'b1);
    countLow("R9 restart", n);
    check("R9 restart count", n, 5);
    startCycle(2'b11, 1'b1);
    startCycle(2'b01, 1'b1);
    countLow("R9 restart to ram", n);
    check("R9 restart to ram", n, 1);
  endtask

  task automatic testLevels();
    @(negedge clk);
    ale = 1'b1;
    regionCode = 2'b10;
    memNotIo = 1'b1;
    repeat (6) begin
      @(posedge clk); #2;
      check("R10 ale high", rdyReq, 1);
    end
    @(negedge clk);
    ale = 1'b0;
    @(posedge clk); #2;
    check("R2 fall loads", rdyReq, 0);
    repeat (2) @(posedge clk);
    #2;
    repeat (8) begin
      check("R10 ale low", rdyReq, 1);
      @(posedge clk); #2;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    testReset();
    testRegions();
    testConfig();
    testRestart();
    testLevels();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #100000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule